// File: doc/BRIEF.md
# MDIO Management Master with Clause 22 and Clause 45 Frames

This block is a memory-mapped station-management master. It drives the management clock and the bidirectional management data line toward one or more Ethernet PHYs. Software sets a clause-select bit and an MDC divider, loads the PHY address, the register or device number and a 16-bit data word, and then writes a start bit with a 2-bit access code. The controller serializes one 64-bit management frame and reports progress through a busy flag. When a read frame finishes, the 16 bits returned by the PHY appear in a read-data register.

The same small access-code set means different things depending on the clause bit. In Clause 22 mode the codes select a read or a write. In Clause 45 mode they select an address frame, a write frame or a read frame. A complete Clause 45 access is therefore two transactions: an address frame that carries the register address taken from the write-data register, followed by a data frame. The frame contents are captured when the frame starts, and a start written while a frame is running is ignored.

Top module: `mdio_ctrl`

## Requirements
- R1: Register map, byte offsets on `addr_i`. 0x40 is the mode register: [8] selects the clause (0 = Clause 22, 1 = Clause 45) and [7:0] holds the divider. 0x44 is the address register: [12:8] is the PHY address and [4:0] the register or device number. 0x48 is the write-data register, [15:0]. 0x4C is the read-data register, [15:0], and it is read-only. 0x50 is the command register: [8] is start (it reads back as 0), [1:0] is the access code and [16] is busy. Every field is 0 after reset, and the writable fields read back what was written.
- R2: A command write with bit 8 set and a valid code sets busy in the next cycle. Busy clears on the falling MDC edge that ends bit 64. Invalid codes start nothing: codes 2 and 3 in Clause 22 mode, and code 3 in Clause 45 mode.
- R3: A start written while busy is 1 is ignored. This includes the cycle in which the last bit completes. Such a write does not alter the frame in flight.
- R4: A frame is 64 bits, sent MSB first, in this order: 32 ones, start (2), opcode (2), PHY address (5), register or device (5), turnaround (2), data (16).
- R5: Clause 22 frames use start 01. Code 0 is a read with opcode 10. Code 1 is a write with opcode 01, turnaround 10 and data from the write-data register.
- R6: Clause 45 frames use start 00. Code 0 is an address frame with opcode 00, code 1 a write with opcode 01, and code 2 a read with opcode 11. For address and write frames, the data field is the write-data register and the turnaround is 10.
- R7: MDC is low while idle. Each MDC half-period lasts divider+1 system clocks. MDIO changes only on falling MDC edges and is sampled on rising edges.
- R8: In a read frame the master drives bits 1 to 46 and releases MDIO (`mdio_oe_o` = 0) from the turnaround to the end of the frame. The 16 bits sampled after the turnaround, MSB first, are loaded into the read-data register when the frame completes.
- R9: The read-data register holds its value until the next read frame completes. Write and address frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the pad |
| mdio_o | output | 1 | Management data to the pad |
| mdio_oe_o | output | 1 | Pad output enable for MDIO |

## Verification
A start write and the completion of a frame can land in the same cycle: busy is cleared on the same edge that would accept a new command. The bench provokes this by repeating a start write with a different access code on every cycle until it sees busy low. The last of these writes is then sampled on exactly the completion edge. The result is judged by three checks: busy must stay low afterwards, no further MDC edge may appear, and the bits the bench's PHY model captured must still match the original write frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;

  typedef struct packed {
    logic        c45;
    logic [1:0]  code;
    logic [4:0]  phy;
    logic [4:0]  reg_dev;
    logic [15:0] data;
  } mdio_req_t;

  function automatic logic req_valid(mdio_req_t r);
    return r.c45 ? (r.code != 2'd3) : (r.code < 2'd2);
  endfunction

  function automatic logic req_is_read(mdio_req_t r);
    return r.c45 ? (r.code == 2'd2) : (r.code == 2'd0);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
    logic [1:0] st, op;
    st = r.c45 ? 2'b00 : 2'b01;
    if (r.c45) begin
      case (r.code)
        2'd0:    op = 2'b00;
        2'd1:    op = 2'b01;
        default: op = 2'b11;
      endcase
    end else begin
      op = (r.code == 2'd0) ? 2'b10 : 2'b01;
    end
    return {32'hFFFF_FFFF, st, op, r.phy, r.reg_dev, 2'b10, r.data};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = en_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  mdio_req_t   req_i,
  input  logic        mdc_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        rd_done_o,
  output logic [15:0] rd_data_o
);
  logic                  busy_q, rd_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sr_q;
  logic [15:0]           cap_q;
  logic                  last_bit;

  assign last_bit  = busy_q && fall_i && (idx_q == IDX_W'(FRAME_BITS-1));
  assign busy_o    = busy_q;
  assign mdio_o    = sr_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));
  assign rd_done_o = last_bit && rd_q;
  assign rd_data_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sr_q   <= '1;
      cap_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      rd_q   <= req_is_read(req_i);
      idx_q  <= '0;
      sr_q   <= build_frame(req_i);
      cap_q  <= '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          sr_q   <= '1;
        end else begin
          idx_q <= idx_q + 1'b1;
          sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(launch_i));
  // R2
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(fall_i));
  // R7
  fall_when_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |-> mdc_i);
  // R7
  mdio_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $past(fall_i));
  // R8
  drive_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q < IDX_W'(TA_IDX)) |-> mdio_oe_o);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             rd_done_i,
  input  logic [15:0]      rd_data_i,
  output logic             launch_o,
  output mdio_req_t        req_o,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [7:0] OFF_MODE = 8'h40;
  localparam logic [7:0] OFF_ADDR = 8'h44;
  localparam logic [7:0] OFF_WDAT = 8'h48;
  localparam logic [7:0] OFF_RDAT = 8'h4C;
  localparam logic [7:0] OFF_CMD  = 8'h50;

  logic             c45_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       phy_q, low_q;
  logic [15:0]      wdat_q, rdat_q;
  logic [1:0]       code_q;
  logic             wr;

  assign wr    = req_i && we_i;
  assign div_o = div_q;

  always_comb begin
    req_o.c45     = c45_q;
    req_o.code    = wdata_i[1:0];
    req_o.phy     = phy_q;
    req_o.reg_dev = low_q;
    req_o.data    = wdat_q;
  end

  assign launch_o = wr && (addr_i == OFF_CMD) && wdata_i[8] && !busy_i && req_valid(req_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c45_q  <= 1'b0;
      div_q  <= '0;
      phy_q  <= '0;
      low_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      code_q <= '0;
    end else begin
      if (wr) begin
        case (addr_i)
          OFF_MODE: begin c45_q <= wdata_i[8]; div_q <= wdata_i[DIV_W-1:0]; end
          OFF_ADDR: begin phy_q <= wdata_i[12:8]; low_q <= wdata_i[4:0]; end
          OFF_WDAT: wdat_q <= wdata_i[15:0];
          OFF_CMD:  code_q <= wdata_i[1:0];
          default: ;
        endcase
      end
      if (rd_done_i) rdat_q <= rd_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_MODE: begin rdata_o[8] = c45_q; rdata_o[DIV_W-1:0] = div_q; end
      OFF_ADDR: begin rdata_o[12:8] = phy_q; rdata_o[4:0] = low_q; end
      OFF_WDAT: rdata_o[15:0] = wdat_q;
      OFF_RDAT: rdata_o[15:0] = rdat_q;
      OFF_CMD:  begin rdata_o[16] = busy_i; rdata_o[1:0] = code_q; end
      default: ;
    endcase
  end

  // R3
  no_launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> !busy_i);
  // R9
  rdat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(rdat_q));
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic             busy, launch, rd_done, rise, fall;
  logic [15:0]      rd_data;
  logic [DIV_W-1:0] div;
  mdio_req_t        req;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .rd_done_i(rd_done), .rd_data_i(rd_data),
    .launch_o(launch), .req_o(req), .div_o(div)
  );

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .en_i(busy), .div_i(div),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame u_frame (
    .clk_i, .rst_ni, .launch_i(launch), .req_i(req),
    .mdc_i(mdc_o), .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .mdio_o, .mdio_oe_o,
    .rd_done_o(rd_done), .rd_data_o(rd_data)
  );
endmodule

// File: tb/mdio_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdio_in, mdio_out, mdio_oe;

  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  int          rise_cnt = 0;
  logic [63:0] cap_val, cap_oe;
  logic [15:0] phy_rd = '0;
  realtime     t_r0, t_r1;
  logic [7:0]  cur_div = 8'd0;

  always #2.5 clk = ~clk;

  mdio_ctrl u_mdio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  // PHY model: records each bit at rising MDC, returns data in read bits
  assign mdio_in = (rise_cnt >= 48 && rise_cnt < 64) ? phy_rd[63-rise_cnt] : 1'b1;
  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap_val[63-rise_cnt] = mdio_out;
      cap_oe[63-rise_cnt]  = mdio_oe;
    end
    if (rise_cnt == 0) t_r0 = $realtime;
    if (rise_cnt == 1) t_r1 = $realtime;
    rise_cnt = rise_cnt + 1;
  end

  task automatic check(input string req_s, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] code,
      input logic [4:0] phy, input logic [4:0] low, input logic [15:0] d);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (c45) op = (code == 0) ? 2'b00 : (code == 1) ? 2'b01 : 2'b11;
    else     op = (code == 0) ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, st, op, phy, low, 2'b10, d};
  endfunction

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(8'h50, r);
      if (!r[16]) break;
    end
  endtask

  task automatic run_frame(input string tag, input logic c45, input logic [1:0] code,
      input logic [4:0] phy, input logic [4:0] low, input logic [15:0] d, input logic [15:0] prd);
    logic [31:0] r;
    logic [63:0] exp, mask;
    bit rd;
    rd   = c45 ? (code == 2) : (code == 0);
    mask = rd ? {{46{1'b1}}, 18'b0} : '1;
    bus_wr(8'h40, {23'b0, c45, cur_div});
    bus_wr(8'h44, {19'b0, phy, 3'b0, low});
    bus_wr(8'h48, {16'b0, d});
    phy_rd = prd; rise_cnt = 0; cap_val = '0; cap_oe = '0;
    bus_wr(8'h50, {23'b0, 1'b1, 6'b0, code});
    bus_rd(8'h50, r);
    check({tag, " R2 busy after start"}, 64'(r[16]), 64'd1);
    wait_idle();
    exp = exp_frame(c45, code, phy, low, d);
    check({tag, " R4 bit count"}, 64'(rise_cnt), 64'd64);
    check({tag, " R4 frame bits"}, cap_val & mask, exp & mask);
    check({tag, " R8 output enable"}, cap_oe, mask);
    check({tag, " R7 mdc idle low"}, 64'(mdc), 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    for (int a = 'h40; a <= 'h50; a += 4) begin
      bus_rd(8'(a), r);
      check("R1 reset value", 64'(r), 64'd0);
    end
    check("R7 reset mdc", {62'b0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    bus_wr(8'h40, 32'hFFFF_FF05); bus_rd(8'h40, r); check("R1 mode rb", 64'(r), 64'h105);
    bus_wr(8'h44, 32'hFFFF_FFFF); bus_rd(8'h44, r); check("R1 addr rb", 64'(r), 64'h1F1F);
    bus_wr(8'h48, 32'h1234_ABCD); bus_rd(8'h48, r); check("R1 wdata rb", 64'(r), 64'hABCD);
    bus_wr(8'h4C, 32'hFFFF_FFFF); bus_rd(8'h4C, r); check("R1 rdata read-only", 64'(r), 64'h0);
    bus_wr(8'h40, 32'h0);
  endtask

  task automatic t_c22();
    logic [31:0] r;
    run_frame("c22 write R5", 1'b0, 2'd1, 5'h05, 5'h1A, 16'hC3A5, 16'h0);
    run_frame("c22 read R5", 1'b0, 2'd0, 5'h12, 5'h03, 16'h0, 16'hBEEF);
    bus_rd(8'h4C, r); check("R8 c22 read data", 64'(r), 64'hBEEF);
  endtask

  task automatic t_c45();
    logic [31:0] r;
    run_frame("c45 addr R6", 1'b1, 2'd0, 5'h03, 5'h07, 16'h8001, 16'h5555);
    bus_rd(8'h4C, r); check("R9 rdata held after addr", 64'(r), 64'hBEEF);
    run_frame("c45 write R6", 1'b1, 2'd1, 5'h1F, 5'h01, 16'h0F0F, 16'h1111);
    bus_rd(8'h4C, r); check("R9 rdata held after write", 64'(r), 64'hBEEF);
    run_frame("c45 read R6", 1'b1, 2'd2, 5'h0A, 5'h1E, 16'h0, 16'h7A3C);
    bus_rd(8'h4C, r); check("R8 c45 read data", 64'(r), 64'h7A3C);
  endtask

  task automatic t_invalid();
    logic [31:0] r;
    bus_wr(8'h40, 32'h0); rise_cnt = 0;
    bus_wr(8'h50, 32'h102);
    repeat (8) @(negedge clk);
    bus_rd(8'h50, r); check("R2 c22 code2 ignored busy", 64'(r[16]), 64'd0);
    bus_wr(8'h40, 32'h100);
    bus_wr(8'h50, 32'h103);
    repeat (8) @(negedge clk);
    bus_rd(8'h50, r); check("R2 c45 code3 ignored busy", 64'(r[16]), 64'd0);
    check("R2 no mdc edges", 64'(rise_cnt), 64'd0);
  endtask

  task automatic t_div();
    cur_div = 8'd2;
    run_frame("div R7", 1'b0, 2'd1, 5'h01, 5'h02, 16'h00FF, 16'h0);
    check("R7 mdc period", 64'(int'((t_r1 - t_r0) * 10)), 64'd300);
    cur_div = 8'd0;
  endtask

  task automatic t_busy_start();
    logic [63:0] exp;
    int guard;
    bus_wr(8'h40, 32'h0);
    bus_wr(8'h44, {19'b0, 5'h09, 3'b0, 5'h11});
    bus_wr(8'h48, 32'hA5A5);
    rise_cnt = 0; cap_val = '0;
    bus_wr(8'h50, 32'h101);
    // spam read starts each cycle until busy is seen low
    guard = 0;
    @(negedge clk); req = 1; we = 1; addr = 8'h50; wdata = 32'h100;
    while (u_mdio_ctrl.rdata_o[16] && guard < 1000) begin
      @(negedge clk); guard++;
    end
    req = 0; we = 0;
    repeat (10) @(negedge clk);
    addr = 8'h50; #1;
    check("R3 busy low after coincident start", 64'(rdata[16]), 64'd0);
    check("R3 no extra mdc edges", 64'(rise_cnt), 64'd64);
    exp = exp_frame(1'b0, 2'd1, 5'h09, 5'h11, 16'hA5A5);
    check("R3 frame undisturbed", cap_val, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_c22();
    t_c45();
    t_invalid();
    t_div();
    t_busy_start();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule